// File: doc/BRIEF.md
# Logic Event Timer

This block times a digital event on one of a small set of input pins. A start pulse arrives with a pin number, and the block latches that pin's mode bit and target-level bit. From then on it counts ticks of a fixed period (nominally 1.6 µs, made by dividing the core clock). At the end of a measurement it presents a 16-bit tick count together with a done flag. An overflow flag is also raised when the count ran out before the event came.

Two measurement kinds share one counter. In edge mode the count runs from the start pulse until the selected pin moves from the non-target level into the target level. In width mode the block first waits, without counting, for the pin to enter the target level. It then counts until the pin leaves it again.

Only a real change of level counts as an entry: a pin that already sits at the target level when timing begins must leave that level and come back. Pin 0 and any number past the last pin cannot be timed, and a start that names one of them is ignored. A full 16-bit count at 1.6 µs per tick spans roughly 104 ms.

Top module: `logic_event_timer`

## Requirements
- R1: While reset is held and in the cycle after it is released, `done_o` and `overflow_o` are 0 and `result_o` is 0.
- R2: A start with `sel_i` in 1..4 is accepted. In the next cycle `done_o` and `overflow_o` are 0. The measurement uses `mode_i[sel_i]` and `target_i[sel_i]` as they were in the start cycle. One tick lasts `TICK_DIV` clock cycles.
- R3: With mode bit 0 (edge), let the selected pin first show the target level after having been at the non-target level at the clock edge K cycles after the start edge. Then `done_o` is 1 from the following cycle, and `result_o` equals floor((K-1)/`TICK_DIV`).
- R4: A selected pin that is already at the target level when the start is accepted does not end an edge measurement, and does not begin the counting phase of a width measurement. Only a later move from the non-target level into the target level counts.
- R5: With mode bit 1 (width), nothing is counted while waiting for the pin to enter the target level. Let the entry be seen at one edge and the exit seen M cycles later. Then `result_o` equals floor((M-1)/`TICK_DIV`) and `done_o` rises in the cycle after the exit edge.
- R6: Target bit 1 makes high the target level. Target bit 0 makes low the target level, so in edge mode a falling change ends the measurement.
- R7: If 65536 ticks pass in the counting phase with no terminating change, the measurement ends at the 65536th tick with `done_o`=1, `overflow_o`=1 and `result_o`=16'hFFFF.
- R8: A start whose `sel_i` is 0 or greater than 4 has no effect. A measurement that is running goes on, and a finished result, `done_o` and `overflow_o` remain as they were.
- R9: An accepted start while a measurement runs abandons it. Counting restarts from zero using the new pin and configuration.
- R10: After `done_o` rises, `done_o`, `overflow_o` and `result_o` keep their values until the next accepted start, whatever the pins do.
- R11: Level changes on pins other than the selected one have no effect on a running measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin timing |
| sel_i | input | 3 | Pin number for the request; only 1..4 are accepted |
| mode_i | input | 5 | Mode bit per pin: 0 edge, 1 width |
| target_i | input | 5 | Target-level bit per pin: 1 high, 0 low |
| pins_i | input | 5 | Pin levels, already synchronous to `clk` |
| result_o | output | 16 | Measured tick count |
| done_o | output | 1 | Measurement finished, held until next accepted start |
| overflow_o | output | 1 | Count ran out before the event, held with `done_o` |

## Verification
The hardest state to reach is saturation: the counter has to run through all 65536 ticks with the selected pin held still at the non-target level. The bench accepts an edge-mode start and then counts cycles until `done_o` appears. It confirms that saturation lands on exactly 65536 times `TICK_DIV` cycles, and that a further start clears the overflow flag. The bench also lines up harder timing cases. It sends a pin-0 start in the middle of a run, restarts on top of a live count, and starts with a pin already at target that must leave the level and re-enter before anything ends.

// File: rtl/let_pkg.sv
package let_pkg;

    // Lowest pin number that can be timed; pin 0 is never timed.
    localparam int FIRST_TIMED_PIN = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,   // width mode: waiting for entry into target level
        ST_MEAS = 2'd2    // counting ticks
    } let_state_e;

    typedef struct packed {
        logic width_mode;   // 0: edge timing, 1: width timing
        logic target_hi;    // target level
    } let_cfg_t;

    function automatic logic pin_is_timeable(input int sel, input int num_pins);
        return (sel >= FIRST_TIMED_PIN) && (sel < num_pins);
    endfunction

endpackage

// File: rtl/let_tick_gen.sv
module let_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/let_level_watch.sv
module let_level_watch #(
    parameter int NUM_PINS = 5,
    parameter int SEL_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SEL_W-1:0]    load_sel,
    input  logic [NUM_PINS-1:0] pins,
    input  logic                target,
    output logic                entry,
    output logic                leave
);
    logic [SEL_W-1:0] sel_q;
    logic             prev_q;
    logic             cur_lvl;
    logic             load_lvl;

    always_comb begin
        cur_lvl  = 1'b0;
        load_lvl = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_q == SEL_W'(i))    cur_lvl  = pins[i];
            if (load_sel == SEL_W'(i)) load_lvl = pins[i];
        end
    end

    // A change is judged against the level seen one cycle before; on a
    // load the new pin's present level becomes the reference.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            prev_q <= 1'b0;
        end else if (load) begin
            sel_q  <= load_sel;
            prev_q <= load_lvl;
        end else begin
            prev_q <= cur_lvl;
        end
    end

    assign entry = !load && (prev_q != target) && (cur_lvl == target);
    assign leave = !load && (prev_q == target) && (cur_lvl != target);
endmodule

// File: rtl/let_span_counter.sv
module let_span_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         full
);
    assign full = &count;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (tick && !full) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/logic_event_timer.sv
module logic_event_timer
    import let_pkg::*;
#(
    parameter int NUM_PINS = 5,
    parameter int TICK_DIV = 2,
    parameter int CNT_W    = 16,
    localparam int SEL_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [NUM_PINS-1:0] mode_i,
    input  logic [NUM_PINS-1:0] target_i,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [CNT_W-1:0]    result_o,
    output logic                done_o,
    output logic                overflow_o
);
    let_state_e       state_q;
    let_cfg_t         cfg_q;
    let_cfg_t         cfg_new;
    logic             accept;
    logic             entry;
    logic             leave;
    logic             arm_hit;
    logic             finish;
    logic             tick;
    logic             cnt_clear;
    logic             run;
    logic             full;
    logic [CNT_W-1:0] cnt_q;

    assign accept = start_i && pin_is_timeable(int'(sel_i), NUM_PINS);

    always_comb begin
        cfg_new = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_i == SEL_W'(i)) begin
                cfg_new.width_mode = mode_i[i];
                cfg_new.target_hi  = target_i[i];
            end
        end
    end

    assign arm_hit   = (state_q == ST_ARM) && entry;
    assign finish    = (state_q == ST_MEAS) && (cfg_q.width_mode ? leave : entry);
    assign cnt_clear = accept || arm_hit;
    assign run       = (state_q == ST_MEAS) && !accept;

    let_level_watch #(
        .NUM_PINS (NUM_PINS),
        .SEL_W    (SEL_W)
    ) u_watch (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_sel (sel_i),
        .pins     (pins_i),
        .target   (cfg_q.target_hi),
        .entry    (entry),
        .leave    (leave)
    );

    let_tick_gen #(
        .DIV   (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .run   (run),
        .tick  (tick)
    );

    let_span_counter #(
        .W     (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .tick  (tick),
        .count (cnt_q),
        .full  (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            result_o   <= '0;
            done_o     <= 1'b0;
            overflow_o <= 1'b0;
        end else if (accept) begin
            cfg_q      <= cfg_new;
            result_o   <= '0;
            done_o     <= 1'b0;
            overflow_o <= 1'b0;
            state_q    <= cfg_new.width_mode ? ST_ARM : ST_MEAS;
        end else begin
            unique case (state_q)
                ST_ARM: begin
                    if (entry) state_q <= ST_MEAS;
                end
                ST_MEAS: begin
                    if (finish) begin
                        result_o <= cnt_q;
                        done_o   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else if (tick && full) begin
                        result_o   <= '1;
                        done_o     <= 1'b1;
                        overflow_o <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/let_checker.sv
module let_checker
    import let_pkg::*;
#(
    parameter int NUM_PINS = 5,
    parameter int CNT_W    = 16,
    parameter int SEL_W    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [SEL_W-1:0] sel_i,
    input logic [CNT_W-1:0] result_o,
    input logic             done_o,
    input logic             overflow_o,
    input let_state_e       state_q,
    input logic [CNT_W-1:0] count
);
    logic ok_sel;
    assign ok_sel = pin_is_timeable(int'(sel_i), NUM_PINS);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!done_o && !overflow_o && result_o == '0));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && ok_sel) |=> (!done_o && !overflow_o));

    assert_wait_uncounted_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARM) |-> (count == '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> (done_o && result_o == '1));

    assert_reject_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !ok_sel && done_o) |=> (done_o && $stable(result_o)));

    assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
        (done_o && !(start_i && ok_sel)) |=>
            (done_o && $stable(result_o) && $stable(overflow_o)));
endmodule

bind logic_event_timer let_checker #(
    .NUM_PINS (NUM_PINS),
    .CNT_W    (CNT_W),
    .SEL_W    (SEL_W)
) u_let_checker (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .sel_i      (sel_i),
    .result_o   (result_o),
    .done_o     (done_o),
    .overflow_o (overflow_o),
    .state_q    (state_q),
    .count      (cnt_q)
);

// File: tb/logic_event_timer_test.sv
module logic_event_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  sel = '0;
    logic [4:0]  mode = '0;
    logic [4:0]  tgt = '0;
    logic [4:0]  pins = '0;
    logic [15:0] result;
    logic        done;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic_event_timer #(
        .NUM_PINS (5),
        .TICK_DIV (DIV),
        .CNT_W    (16)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .sel_i      (sel),
        .mode_i     (mode),
        .target_i   (tgt),
        .pins_i     (pins),
        .result_o   (result),
        .done_o     (done),
        .overflow_o (ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Returns just after the clock edge that samples the start request.
    task automatic kick(input logic [2:0] s);
        @(negedge clk);
        start = 1'b1;
        sel   = s;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        pins = '0; mode = '0; tgt = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        wait_n(3);
        chk("R1", "done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done after reset", done, 0);
        chk("R1", "overflow after reset", ovf, 0);
        chk("R1", "result after reset", result, 0);
    endtask

    task automatic t_edge(input int p, input logic hi, input int n, input string req);
        settle();
        tgt[p] = hi; mode[p] = 1'b0; pins[p] = ~hi;
        kick(3'(p));
        chk("R2", "done cleared by start", done, 0);
        wait_n(n);
        chk(req, "done before entry", done, 0);
        pins[p] = hi;
        @(negedge clk);
        chk(req, "done after entry", done, 1);
        chk(req, "edge result", result, n / DIV);
        chk(req, "overflow on normal end", ovf, 0);
    endtask

    task automatic t_edge_already_at_target();
        settle();
        tgt[1] = 1'b1; pins[1] = 1'b1;
        kick(3'd1);
        wait_n(20);
        chk("R4", "edge not ended by initial level", done, 0);
        pins[1] = 1'b0;
        wait_n(4);
        pins[1] = 1'b1;
        @(negedge clk);
        chk("R4", "edge result after real entry", result, 24 / DIV);
    endtask

    task automatic t_width(input logic hi, input int pre, input int m, input string req);
        settle();
        tgt[4] = hi; mode[4] = 1'b1; pins[4] = ~hi;
        kick(3'd4);
        wait_n(pre);
        chk(req, "width done during wait", done, 0);
        pins[4] = hi;
        @(negedge clk);
        wait_n(m);
        chk(req, "width done while at target", done, 0);
        pins[4] = ~hi;
        @(negedge clk);
        chk(req, "width done after leave", done, 1);
        chk(req, "width result", result, m / DIV);
    endtask

    task automatic t_width_already_at_target();
        settle();
        tgt[4] = 1'b1; mode[4] = 1'b1; pins[4] = 1'b1;
        kick(3'd4);
        wait_n(6);
        pins[4] = 1'b0;
        @(negedge clk);
        chk("R4", "width not ended by leaving initial level", done, 0);
        wait_n(3);
        pins[4] = 1'b1;
        @(negedge clk);
        wait_n(10);
        pins[4] = 1'b0;
        @(negedge clk);
        chk("R4", "width result after real entry", result, 10 / DIV);
    endtask

    task automatic t_reject();
        logic [15:0] held;
        held = result;
        kick(3'd0);
        @(negedge clk);
        chk("R8", "done after pin0 start", done, 1);
        chk("R8", "result after pin0 start", result, held);
        kick(3'd5);
        kick(3'd7);
        @(negedge clk);
        chk("R8", "result after out-of-range start", result, held);
        // Rejected start in the middle of a run: count continues.
        settle();
        tgt[2] = 1'b1;
        kick(3'd2);
        wait_n(4);
        kick(3'd0);
        wait_n(4);
        chk("R8", "run continues after pin0 start", done, 0);
        pins[2] = 1'b1;
        @(negedge clk);
        chk("R8", "result spans rejected start", result, 10 / DIV);
    endtask

    task automatic t_restart();
        settle();
        tgt[2] = 1'b1;
        kick(3'd2);
        wait_n(30);
        mode[2] = 1'b0;
        kick(3'd2);
        wait_n(8);
        pins[2] = 1'b1;
        @(negedge clk);
        chk("R9", "result after restart", result, 8 / DIV);
    endtask

    task automatic t_other_pins();
        settle();
        tgt = '1;
        kick(3'd2);
        wait_n(3);
        pins[1] = 1'b1; pins[3] = 1'b1; pins[4] = 1'b1;
        wait_n(3);
        pins[1] = 1'b0;
        wait_n(2);
        chk("R11", "other pins leave run going", done, 0);
        pins[2] = 1'b1;
        @(negedge clk);
        chk("R11", "result with other pins toggling", result, 8 / DIV);
    endtask

    task automatic t_hold();
        logic [15:0] held;
        held = result;
        wait_n(10);
        pins[2] = 1'b0;
        wait_n(3);
        pins[2] = 1'b1;
        wait_n(3);
        chk("R10", "done held", done, 1);
        chk("R10", "result held", result, held);
    endtask

    task automatic t_overflow();
        int k;
        settle();
        tgt[2] = 1'b1;
        kick(3'd2);
        k = 0;
        while (!done && k < 140000) begin
            @(negedge clk);
            k = k + 1;
        end
        chk("R7", "cycles to saturation", k, 65536 * DIV);
        chk("R7", "saturated result", result, 16'hFFFF);
        chk("R7", "overflow flag", ovf, 1);
        kick(3'd2);
        chk("R2", "overflow cleared by start", ovf, 0);
        pins[2] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_edge(2, 1'b1, 10, "R3");
        t_edge(3, 1'b1, 7, "R3");
        t_edge(3, 1'b0, 9, "R6");
        t_edge_already_at_target();
        t_width(1'b1, 15, 12, "R5");
        t_width(1'b0, 5, 9, "R6");
        t_width_already_at_target();
        t_reject();
        t_restart();
        t_other_pins();
        t_hold();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule